// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

A single-port synchronous SRAM that lets a host mix reads and writes on consecutive clocks without an idle bus cycle. The data slot of a write trails its command by exactly as many clock edges as the data of a read does. The shared data bus therefore carries one transfer per slot in command order. The bus is modelled as separate `dIn`, `dOut` and `dOe` signals. Commands are a new load (with its own address) or an advance, which steps an internal wrapping burst counter and repeats the type and lane mask of the command that loaded it.

Two latency variants are picked by `flowThru`, which is only changed while reset is held. In the pipelined variant, the data slot is the second accepted cycle after the command. Read data leaves a register and write data is captured at the second accepted edge after the command edge. In the flow-through variant, the data slot is the cycle right after the command edge. Read data comes straight from the array and write data is captured at the next accepted edge. A low clock enable freezes every stage. A read that follows a write to the same word, with that write still pending, sees the newly written lanes.

Top module: `lw_sram`

## Requirements
- R1: While `rstN` is low and after it rises, with no command yet, `dOe` is 0, and every word reads back as zero.
- R2: Pipelined (`flowThru`=0): a read load (`advLd`=0, `ce`=1, `we`=0) accepted at edge E0 drives `dOe`=1 and that word on `dOut` after the next accepted edge E1, held until the edge after that.
- R3: Pipelined: for a write load (`we`=1) accepted at E0, `dIn` is sampled at the second accepted edge after E0. Only the lanes whose `byteEn[i]`=1 are written, and lane i is `dIn[i*LANE_W +: LANE_W]`.
- R4: Flow-through (`flowThru`=1): read data and `dOe`=1 appear in the cycle right after the accepted command edge. Write data is sampled at the next accepted edge.
- R5: A write whose `byteEn` is all zero, whether loaded or advanced in a burst, leaves every word unchanged.
- R6: `dOe` is 0 during every data slot that belongs to a write, a deselect or a non-transfer.
- R7: With `advLd`=1 after a load with `ce`=1, the address advances: its low 2 bits count up by one modulo 4 and the upper bits are held. Each step repeats the loaded read/write type and `byteEn`, and `ce`, `we`, `byteEn` and `addr` are ignored. An advance after reset or after a deselect is no transfer.
- R8: `cke`=0 freezes the block for that edge. No command, address or data is taken, no word is written, and `dOe`/`dOut` hold.
- R9: Reads and writes may alternate on consecutive cycles. A read of a word whose write is still pending returns the new data in the written lanes and the old data in the other lanes.
- R10: A load with `ce`=0 is a deselect. No transfer takes place, `dOe` is 0 in its data slot, and any burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| flowThru | input | 1 | 1 = flow-through latency, 0 = pipelined; static outside reset |
| cke | input | 1 | Clock enable, 1 = edge accepted |
| advLd | input | 1 | 0 = load new command, 1 = advance burst |
| ce | input | 1 | Chip enable for loads, 1 = selected |
| we | input | 1 | 1 = write, 0 = read (loads only) |
| byteEn | input | LANES | Per-lane write enables |
| addr | input | ADDR_W | Word address for loads |
| dIn | input | LANES*LANE_W | Write data in its data slot |
| dOut | output | LANES*LANE_W | Read data |
| dOe | output | 1 | Bus drive enable for read data |

## Verification
The bench drives runs of back-to-back writes followed by back-to-back reads, which separate the write capture slot from the read latency. It then interleaves writes and reads of the same word, which exposes a missing or wrong-lane bypass. Partial-lane writes and all-zero-lane writes, in both loads and bursts, show lane gating and aborts apart. Bursts that start in mid-group reveal counter wrap and carry errors, and advances after a deselect show whether a burst ends. Random traffic with random clock-enable drops shows whether any stage slips during a stall. The whole sequence runs under both latency variants.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_t;

  typedef struct packed {
    logic wrEn;
    logic capture;
    logic oeSlot;
    logic bypass;
  } ctlStrobe_t;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  logic              cke,
  input  logic              advLd,
  input  logic              ce,
  input  logic              we,
  input  logic [LANES-1:0]  byteEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrBe,
  output logic [ADDR_W-1:0] rdAddr
);

  opKind_t           s1Kind, s2Kind, burstKind, nKind, slotKind;
  logic [ADDR_W-1:0] s1Addr, s2Addr, burstAddr, nAddr, stepAddr;
  logic [LANES-1:0]  s1Be, s2Be, burstBe, nBe;
  logic              burstOn;

  generate
    if (ADDR_W > BURST_W) begin : gSplit
      logic [BURST_W-1:0] lowNext;
      assign lowNext  = burstAddr[BURST_W-1:0] + 1'b1;
      assign stepAddr = {burstAddr[ADDR_W-1:BURST_W], lowNext};
    end else begin : gWhole
      assign stepAddr = burstAddr + 1'b1;
    end
  endgenerate

  always_comb begin
    nKind = OP_NONE;
    nAddr = burstAddr;
    nBe   = burstBe;
    if (!advLd) begin
      nAddr = addr;
      nBe   = byteEn;
      if (ce) nKind = we ? OP_WRITE : OP_READ;
    end else if (burstOn) begin
      nKind = burstKind;
      nAddr = stepAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Kind    <= OP_NONE;
      s1Addr    <= '0;
      s1Be      <= '0;
      s2Kind    <= OP_NONE;
      s2Addr    <= '0;
      s2Be      <= '0;
      burstOn   <= 1'b0;
      burstKind <= OP_NONE;
      burstAddr <= '0;
      burstBe   <= '0;
    end else if (cke) begin
      s1Kind <= nKind;
      s1Addr <= nAddr;
      s1Be   <= nBe;
      s2Kind <= s1Kind;
      s2Addr <= s1Addr;
      s2Be   <= s1Be;
      if (!advLd) begin
        burstOn   <= ce;
        burstKind <= nKind;
        burstAddr <= addr;
        burstBe   <= byteEn;
      end else if (burstOn) begin
        burstAddr <= stepAddr;
      end
    end
  end

  // The data slot belongs to the stage whose age matches the chosen latency.
  always_comb begin
    if (flowThru) begin
      slotKind = s1Kind;
      wrAddr   = s1Addr;
      wrBe     = s1Be;
    end else begin
      slotKind = s2Kind;
      wrAddr   = s2Addr;
      wrBe     = s2Be;
    end
  end

  assign rdAddr       = s1Addr;
  assign strb.wrEn    = cke && (slotKind == OP_WRITE);
  assign strb.capture = cke;
  assign strb.oeSlot  = (s1Kind == OP_READ);
  assign strb.bypass  = strb.wrEn && (wrAddr == rdAddr);

endmodule

// File: rtl/lw_sram_dp.sv
module lw_sram_dp
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LANES-1:0]  wrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord, merged, dOutReg;
  logic              dOeReg;

  assign rdWord = mem[rdAddr];

  // Lanes of a write committing at this edge override the stored word.
  generate
    for (genvar l = 0; l < LANES; l++) begin : gLane
      assign merged[l*LANE_W +: LANE_W] = (strb.bypass && wrBe[l])
                                          ? dIn[l*LANE_W +: LANE_W]
                                          : rdWord[l*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (strb.wrEn) begin
      for (int l = 0; l < LANES; l++)
        if (wrBe[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOutReg <= '0;
      dOeReg  <= 1'b0;
    end else if (strb.capture) begin
      dOutReg <= merged;
      dOeReg  <= strb.oeSlot;
    end
  end

  assign dOut = flowThru ? merged : dOutReg;
  assign dOe  = flowThru ? strb.oeSlot : dOeReg;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  logic              cke,
  input  logic              advLd,
  input  logic              ce,
  input  logic              we,
  input  logic [LANES-1:0]  byteEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);

  ctlStrobe_t        strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [LANES-1:0]  wrBe;

  lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flowThru(flowThru), .cke(cke), .advLd(advLd),
    .ce(ce), .we(we), .byteEn(byteEn), .addr(addr), .strb(strb),
    .wrAddr(wrAddr), .wrBe(wrBe), .rdAddr(rdAddr)
  );

  lw_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uDp (
    .clk(clk), .rstN(rstN), .flowThru(flowThru), .strb(strb),
    .wrAddr(wrAddr), .wrBe(wrBe), .rdAddr(rdAddr), .dIn(dIn),
    .dOut(dOut), .dOe(dOe)
  );

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              flowThru,
  input logic              cke,
  input logic              advLd,
  input logic              ce,
  input logic              we,
  input logic              wrEn,
  input logic [DATA_W-1:0] dOut,
  input logic              dOe
);

  // R1
  a_r1_reset_oe: assert property (@(posedge clk) !rstN |=> !dOe);

  // R6
  a_r6_oe_off_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !dOe);

  // R8
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> ($stable(dOe) && (!dOe || $stable(dOut))));

  // R2
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && cke && !advLd && ce && !we) ##1 cke |=> dOe);

  // R10
  a_r10_deselect_oe: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && cke && !advLd && !ce) ##1 cke |=> !dOe);

  // R4
  a_r4_flow_read: assert property (@(posedge clk) disable iff (!rstN)
    (flowThru && cke && !advLd && ce && !we) |=> dOe);

endmodule

bind lw_sram lw_sram_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .flowThru(flowThru), .cke(cke), .advLd(advLd),
  .ce(ce), .we(we), .wrEn(strb.wrEn), .dOut(dOut), .dOe(dOe)
);

// File: tb/lw_sram_test.sv
`timescale 1ns/100ps
module lw_sram_test;

  localparam int ADDR_W = 4;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flowThru = 1'b0;
  logic              cke = 1'b1;
  logic              advLd = 1'b0;
  logic              ce = 1'b0;
  logic              we = 1'b0;
  logic [LANES-1:0]  byteEn = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic              dOe;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  lw_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rstN(rstN), .flowThru(flowThru), .cke(cke), .advLd(advLd),
    .ce(ce), .we(we), .byteEn(byteEn), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOe(dOe)
  );

  // ---------------- behavioural reference ----------------
  typedef struct {
    bit         v;
    bit         w;
    int         a;
    bit [LANES-1:0] be;
  } mop_t;

  logic [DATA_W-1:0] mMem [DEPTH];
  mop_t              hist[$];
  bit                bOn;
  bit                bW;
  int                bA;
  bit [LANES-1:0]    bBe;
  bit                expOe = 0;
  logic [DATA_W-1:0] expData = '0;

  always @(posedge clk) begin
    mop_t slot, nop, show;
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
      hist.delete();
      nop = '{v:0, w:0, a:0, be:'0};
      hist.push_back(nop);
      hist.push_back(nop);
      bOn = 0; bW = 0; bA = 0; bBe = '0;
      expOe = 0; expData = '0;
    end else if (cke) begin
      slot = flowThru ? hist[0] : hist[1];
      if (slot.v && slot.w)
        for (int l = 0; l < LANES; l++)
          if (slot.be[l]) mMem[slot.a][l*LANE_W +: LANE_W] = dIn[l*LANE_W +: LANE_W];
      nop = '{v:0, w:0, a:0, be:'0};
      if (!advLd) begin
        if (ce) nop = '{v:1, w:we, a:int'(addr), be:byteEn};
        bOn = ce; bW = we; bA = int'(addr); bBe = byteEn;
      end else if (bOn) begin
        bA  = (bA & ~3) | ((bA + 1) & 3);
        nop = '{v:1, w:bW, a:bA, be:bBe};
      end
      hist.push_front(nop);
      void'(hist.pop_back());
      show    = flowThru ? hist[0] : hist[1];
      expOe   = show.v && !show.w;
      expData = mMem[show.a];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (dOe !== expOe) begin
        failures++;
        $display("FAIL %s dOe actual=%b expected=%b t=%0t", curReq, dOe, expOe, $time);
      end
      if (expOe) begin
        checks++;
        if (dOut !== expData) begin
          failures++;
          $display("FAIL %s dOut actual=%h expected=%h t=%0t", curReq, dOut, expData, $time);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit k, input bit adv, input bit c, input bit w,
                     input bit [LANES-1:0] b, input int a);
    @(negedge clk); #1;
    cke = k; advLd = adv; ce = c; we = w; byteEn = b;
    addr = ADDR_W'(a); dIn = DATA_W'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, '0, 0);
  endtask

  task automatic doReset(input bit ft);
    @(negedge clk); #1;
    rstN = 0; flowThru = ft; cke = 1; advLd = 0; ce = 0;
    repeat (3) @(negedge clk);
    // R1: output enable off while reset is held
    checks++;
    if (dOe !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset dOe actual=%b expected=0", dOe);
    end
    #1 rstN = 1;
  endtask

  task automatic scenario(input string pfx);
    curReq = {pfx, "R1"};
    cyc(1, 0, 1, 0, '0, 5); cyc(1, 0, 1, 0, '0, 12); idle(3);
    curReq = {pfx, "R3"};
    for (int i = 0; i < 8; i++) cyc(1, 0, 1, 1, 2'b11, i);
    curReq = {pfx, "R2"};
    for (int i = 0; i < 8; i++) cyc(1, 0, 1, 0, '0, i);
    idle(3);
    curReq = {pfx, "R9"};
    cyc(1, 0, 1, 1, 2'b11, 8); cyc(1, 0, 1, 0, '0, 8);
    cyc(1, 0, 1, 1, 2'b01, 8); cyc(1, 0, 1, 0, '0, 8);
    cyc(1, 0, 1, 0, '0, 9);    cyc(1, 0, 1, 1, 2'b10, 9);
    cyc(1, 0, 1, 0, '0, 9);    cyc(1, 0, 1, 1, 2'b11, 9);
    cyc(1, 0, 1, 0, '0, 9);    idle(3);
    curReq = {pfx, "R5"};
    cyc(1, 0, 1, 1, 2'b00, 3); cyc(1, 0, 1, 0, '0, 3); idle(2);
    cyc(1, 0, 1, 1, 2'b00, 4);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 2'b11, 0);
    cyc(1, 0, 1, 0, '0, 4);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 2'b11, 9);
    idle(3);
    curReq = {pfx, "R7"};
    cyc(1, 0, 1, 1, 2'b11, 6);
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, '0, 15);
    cyc(1, 0, 1, 1, 2'b10, 13);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, '0, 0);
    cyc(1, 0, 1, 0, '0, 5);
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 2'b11, 2);
    cyc(1, 0, 1, 0, '0, 14);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, '0, 0);
    curReq = {pfx, "R10"};
    cyc(1, 0, 0, 0, '0, 1);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 2'b11, 1);
    cyc(1, 0, 1, 0, '0, 1); cyc(1, 0, 0, 1, 2'b11, 2); cyc(1, 0, 1, 0, '0, 2);
    idle(3);
    curReq = {pfx, "R6"};
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, i[0], 2'b11, 10 + (i >> 1));
    idle(3);
    curReq = {pfx, "R8"};
    for (int i = 0; i < 80; i++)
      cyc(($urandom % 10) > 2, ($urandom % 4) == 0, ($urandom % 6) != 0,
          $urandom % 2, LANES'($urandom), $urandom % DEPTH);
    cyc(1, 0, 1, 0, '0, 0); cyc(0, 0, 1, 1, 2'b11, 0);
    cyc(0, 0, 1, 1, 2'b11, 1); cyc(1, 0, 1, 0, '0, 1); idle(3);
    curReq = {pfx, "R9"};
    for (int i = 0; i < 200; i++)
      cyc(1, ($urandom % 4) == 0, ($urandom % 8) != 0,
          $urandom % 2, LANES'($urandom), $urandom % 4);
    idle(3);
  endtask

  initial begin
    doReset(0);
    scenario("");
    doReset(1);
    scenario("R4/");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 50000);
    done = 1;
    failures++;
    $display("FAIL watchdog %s actual=timeout expected=finish", curReq);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule